// File: doc/BRIEF.md
# Search-During-Update Ternary CAM on Distributed RAM Cells

This block is a ternary content-addressable memory. Each rule holds a value and a care mask. A rule matches a search key when every bit marked "care" equals the key bit. Bits marked "don't care" match anything. Storage is a grid of small 64-entry RAM cells, each addressed by one 6-bit slice of the key. The rules are split into equal groups, and each group lives in one basic block. Within a block, a cell returns one match bit per rule for its key slice. A rule matches when the bits from all slices of its block agree.

A search is presented with a key and a valid strobe. The registered result (hit flag and lowest matching rule index) appears on the next cycle. To rewrite a rule, software presents an index, value and care mask. The update sequencer then walks all 64 cell addresses of the owning block, writing the rule's column in every cell of that block in parallel. No other block is touched. Searches continue every cycle during the rewrite. Only the rule being rewritten is held out of matching until its new contents are complete.

Top module: `dram_tcam`

## Requirements
- R1: A search presented with `srch_valid` high yields `res_valid` high on the following cycle, with the result for that key. `res_valid` is low on the cycle after `srch_valid` was low.
- R2: A rule matches when `((key ^ value) & care) == 0`. A care bit of 1 requires equality and a care bit of 0 matches either key value.
- R3: When several written rules match, `res_addr` reports the lowest matching rule index.
- R4: When no rule matches, `res_hit` is 0 and `res_addr` is 0.
- R5: An update request (`upd_valid` high while `upd_busy` is low) raises `upd_busy` on the next cycle. `upd_busy` stays high for exactly 64 cycles, one per cell address, and falls on the cycle after the last write.
- R6: An update request made while `upd_busy` is high is ignored. The rule it names keeps its previous contents, and the busy window is not extended.
- R7: During a rewrite, the rule being rewritten never reports a hit, whatever the key.
- R8: During a rewrite, searches are accepted every cycle. All other rules give exactly the results they would give with no update in progress.
- R9: Once `upd_busy` has fallen, the next search sees the new value and mask of the rewritten rule, and its old contents no longer apply.
- R10: After reset, no rule matches any key, `upd_busy` is low and `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srch_valid | input | 1 | Search key is valid this cycle |
| srch_key | input | 12 | Search key (KEY_CHUNKS x 6 bits) |
| res_valid | output | 1 | Result valid (one cycle after the search) |
| res_hit | output | 1 | At least one rule matched |
| res_addr | output | 3 | Lowest matching rule index, 0 on a miss |
| upd_valid | input | 1 | Update request strobe |
| upd_idx | input | 3 | Index of the rule to rewrite |
| upd_value | input | 12 | New rule value |
| upd_care | input | 12 | New care mask (1 = bit must match) |
| upd_busy | output | 1 | Rewrite in progress; new requests ignored |

## Verification
A wrong cell bit shows up at the ports on the first search whose key slice addresses that entry, one cycle after the key is presented. Random keys built from stored values with noise in the don't-care bits reach such entries quickly. A stuck sequencer counter or a wrong busy window shows as `upd_busy` falling early or late against a 64-cycle count. If the per-rule lock fails, the rule being rewritten reports a hit mid-update. Cross-block corruption changes the hit index for other rules on a search issued during the same update window.

// File: rtl/dram_tcam_pkg.sv
package dram_tcam_pkg;

    // Address width of one distributed RAM cell; one key slice per cell.
    localparam int CELL_AW    = 6;
    localparam int CELL_DEPTH = 1 << CELL_AW;

    // Content of one cell entry for one rule: does this address satisfy the
    // rule's value and care mask on this slice?
    function automatic logic cell_entry(input logic [CELL_AW-1:0] addr,
                                        input logic [CELL_AW-1:0] val,
                                        input logic [CELL_AW-1:0] care);
        return ((addr ^ val) & care) == '0;
    endfunction

endpackage

// File: rtl/dram_tcam_cell.sv
module dram_tcam_cell #(
    parameter int AW    = 6,
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_col,
    input  logic             wr_bit,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    // Behavioural model of a small LUT-based RAM: synchronous write with
    // per-column enable, asynchronous read.
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int j = 0; j < WIDTH; j++) begin
                if (wr_col[j]) begin
                    mem_q[wr_addr][j] <= wr_bit;
                end
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/dram_tcam_block.sv
module dram_tcam_block #(
    parameter int CHUNKS = 2,
    parameter int AW     = 6,
    parameter int RPB    = 4
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [RPB-1:0]       wr_col,
    input  logic [CHUNKS-1:0]    wr_bits,
    input  logic [CHUNKS*AW-1:0] key,
    output logic [RPB-1:0]       match
);
    logic [RPB-1:0] slice_hit [CHUNKS];

    generate
        for (genvar c = 0; c < CHUNKS; c++) begin : g_slice
            dram_tcam_cell #(
                .AW    (AW),
                .WIDTH (RPB)
            ) cell_i (
                .clk     (clk),
                .wr_en   (wr_en),
                .wr_addr (wr_addr),
                .wr_col  (wr_col),
                .wr_bit  (wr_bits[c]),
                .rd_addr (key[c*AW +: AW]),
                .rd_data (slice_hit[c])
            );
        end
    endgenerate

    // A rule matches only when every key slice agrees.
    always_comb begin
        match = '1;
        for (int c = 0; c < CHUNKS; c++) begin
            match = match & slice_hit[c];
        end
    end

endmodule

// File: rtl/dram_tcam_updseq.sv
module dram_tcam_updseq
    import dram_tcam_pkg::*;
#(
    parameter int CHUNKS  = 2,
    parameter int N_RULES = 8,
    localparam int KEY_W  = CHUNKS * CELL_AW,
    localparam int IDX_W  = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_valid,
    input  logic [IDX_W-1:0]   upd_idx,
    input  logic [KEY_W-1:0]   upd_value,
    input  logic [KEY_W-1:0]   upd_care,
    output logic               busy,
    output logic [CELL_AW-1:0] wr_addr,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [CHUNKS-1:0]  wr_bits,
    output logic               done
);
    localparam logic [CELL_AW-1:0] LAST_ADDR = CELL_AW'(CELL_DEPTH - 1);

    typedef struct packed {
        logic               busy;
        logic [CELL_AW-1:0] cnt;
        logic [IDX_W-1:0]   idx;
        logic [KEY_W-1:0]   val;
        logic [KEY_W-1:0]   care;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!seq_q.busy) begin
            if (upd_valid) begin
                seq_d.busy = 1'b1;
                seq_d.cnt  = '0;
                seq_d.idx  = upd_idx;
                seq_d.val  = upd_value;
                seq_d.care = upd_care;
            end
        end else begin
            seq_d.cnt = seq_q.cnt + 1'b1;
            if (seq_q.cnt == LAST_ADDR) begin
                seq_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        for (int c = 0; c < CHUNKS; c++) begin
            wr_bits[c] = cell_entry(seq_q.cnt,
                                    seq_q.val[c*CELL_AW +: CELL_AW],
                                    seq_q.care[c*CELL_AW +: CELL_AW]);
        end
    end

    assign busy    = seq_q.busy;
    assign wr_addr = seq_q.cnt;
    assign wr_idx  = seq_q.idx;
    assign done    = seq_q.busy && (seq_q.cnt == LAST_ADDR);

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && seq_q.cnt != LAST_ADDR) |=> seq_q.busy); // R5
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && seq_q.cnt == LAST_ADDR) |=> !seq_q.busy); // R5
    AST_WALK_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.busy) |-> seq_q.cnt == '0); // R5
    AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && upd_valid) |=>
            ($stable(seq_q.idx) && $stable(seq_q.val) && $stable(seq_q.care))); // R6

endmodule

// File: rtl/dram_tcam_prio.sv
module dram_tcam_prio #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec,
    output logic          hit,
    output logic [IW-1:0] addr
);
    logic [N-1:0] below;

    // Scan from the top so the lowest set bit is the one left standing.
    always_comb begin
        hit  = 1'b0;
        addr = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit  = 1'b1;
                addr = IW'(i);
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            below[i] = (i < int'(addr));
        end
        if (hit) begin
            AST_LOWEST_WINS: assert (((vec & below) == '0) && vec[addr]); // R3
        end
    end

endmodule

// File: rtl/dram_tcam.sv
module dram_tcam
    import dram_tcam_pkg::*;
#(
    parameter int N_RULES       = 8,
    parameter int RULES_PER_BLK = 4,
    parameter int KEY_CHUNKS    = 2,
    localparam int KEY_W        = KEY_CHUNKS * CELL_AW,
    localparam int IDX_W        = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srch_valid,
    input  logic [KEY_W-1:0] srch_key,
    output logic             res_valid,
    output logic             res_hit,
    output logic [IDX_W-1:0] res_addr,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [KEY_W-1:0] upd_value,
    input  logic [KEY_W-1:0] upd_care,
    output logic             upd_busy
);
    localparam int NBLK = N_RULES / RULES_PER_BLK;

    logic                     seq_busy;
    logic [CELL_AW-1:0]       seq_addr;
    logic [IDX_W-1:0]         seq_idx;
    logic [KEY_CHUNKS-1:0]    seq_bits;
    logic                     seq_done;
    logic [RULES_PER_BLK-1:0] wr_col;
    logic [N_RULES-1:0]       raw_match;
    logic [N_RULES-1:0]       lock;
    logic [N_RULES-1:0]       eligible;
    logic                     pe_hit;
    logic [IDX_W-1:0]         pe_addr;

    typedef struct packed {
        logic               res_valid;
        logic               res_hit;
        logic [IDX_W-1:0]   res_addr;
        logic [N_RULES-1:0] rule_vld;
    } top_t;

    top_t st_d, st_q;

    dram_tcam_updseq #(
        .CHUNKS  (KEY_CHUNKS),
        .N_RULES (N_RULES)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .upd_idx   (upd_idx),
        .upd_value (upd_value),
        .upd_care  (upd_care),
        .busy      (seq_busy),
        .wr_addr   (seq_addr),
        .wr_idx    (seq_idx),
        .wr_bits   (seq_bits),
        .done      (seq_done)
    );

    // Column of the rule inside its block, and the per-rule lock mask.
    always_comb begin
        for (int j = 0; j < RULES_PER_BLK; j++) begin
            wr_col[j] = (int'(seq_idx) % RULES_PER_BLK) == j;
        end
        for (int i = 0; i < N_RULES; i++) begin
            lock[i] = seq_busy && (int'(seq_idx) == i);
        end
    end

    generate
        for (genvar b = 0; b < NBLK; b++) begin : g_blk
            logic blk_we;
            assign blk_we = seq_busy && ((int'(seq_idx) / RULES_PER_BLK) == b);

            dram_tcam_block #(
                .CHUNKS (KEY_CHUNKS),
                .AW     (CELL_AW),
                .RPB    (RULES_PER_BLK)
            ) blk_i (
                .clk     (clk),
                .wr_en   (blk_we),
                .wr_addr (seq_addr),
                .wr_col  (wr_col),
                .wr_bits (seq_bits),
                .key     (srch_key),
                .match   (raw_match[b*RULES_PER_BLK +: RULES_PER_BLK])
            );
        end
    endgenerate

    assign eligible = raw_match & st_q.rule_vld & ~lock;

    dram_tcam_prio #(
        .N  (N_RULES),
        .IW (IDX_W)
    ) prio_i (
        .vec  (eligible),
        .hit  (pe_hit),
        .addr (pe_addr)
    );

    always_comb begin
        st_d           = st_q;
        st_d.res_valid = srch_valid;
        st_d.res_hit   = srch_valid && pe_hit;
        st_d.res_addr  = (srch_valid && pe_hit) ? pe_addr : '0;
        if (seq_done) begin
            st_d.rule_vld[seq_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.res_valid;
    assign res_hit   = st_q.res_hit;
    assign res_addr  = st_q.res_addr;
    assign upd_busy  = seq_busy;

    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        srch_valid |=> res_valid); // R1
    AST_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_valid |=> !res_valid); // R1
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> res_addr == '0); // R4
    AST_LOCKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_valid && seq_busy) |=> !(res_hit && res_addr == $past(seq_idx))); // R7

endmodule

// File: tb/dram_tcam_tb_top.sv
`timescale 1ns/1ps
module dram_tcam_tb_top;
    localparam int KEY_W = 12;
    localparam int NR    = 8;
    localparam int IW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          srch_valid = 1'b0;
    logic [KEY_W-1:0] srch_key = '0;
    logic          res_valid, res_hit;
    logic [IW-1:0] res_addr;
    logic          upd_valid = 1'b0;
    logic [IW-1:0] upd_idx = '0;
    logic [KEY_W-1:0] upd_value = '0, upd_care = '0;
    logic          upd_busy;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [KEY_W-1:0] m_val  [NR];
    logic [KEY_W-1:0] m_care [NR];
    logic             m_vld  [NR];

    always #4 clk = ~clk;

    dram_tcam dut_i (
        .clk(clk), .rst_n(rst_n), .srch_valid(srch_valid), .srch_key(srch_key),
        .res_valid(res_valid), .res_hit(res_hit), .res_addr(res_addr),
        .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_value(upd_value),
        .upd_care(upd_care), .upd_busy(upd_busy)
    );

    task automatic check(input bit ok, input string req, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    function automatic void model_search(input logic [KEY_W-1:0] key, input bit excl_en,
                                         input int excl, output bit hit, output int idx);
        hit = 1'b0;
        idx = 0;
        for (int i = NR - 1; i >= 0; i--) begin
            if (m_vld[i] && !(excl_en && i == excl) && (((key ^ m_val[i]) & m_care[i]) == '0)) begin
                hit = 1'b1;
                idx = i;
            end
        end
    endfunction

    function automatic logic [KEY_W-1:0] noisy(input int r);
        return m_val[r] ^ (KEY_W'($urandom) & ~m_care[r]);
    endfunction

    // Present one key at a falling edge, sample the registered result one edge later.
    task automatic search(input logic [KEY_W-1:0] key, input bit excl_en, input int excl,
                          input string req);
        bit eh;
        int ei;
        model_search(key, excl_en, excl, eh, ei);
        srch_valid = 1'b1;
        srch_key   = key;
        @(posedge clk);
        @(negedge clk);
        srch_valid = 1'b0;
        check(res_valid && res_hit == eh && int'(res_addr) == ei, req,
              $sformatf("v=%0b hit=%0b addr=%0d key=%h", res_valid, res_hit, res_addr, key),
              $sformatf("v=1 hit=%0b addr=%0d", eh, ei));
    endtask

    task automatic update(input int idx, input logic [KEY_W-1:0] val, input logic [KEY_W-1:0] care,
                          input bit intr, input int intr_idx);
        upd_valid = 1'b1;
        upd_idx   = IW'(idx);
        upd_value = val;
        upd_care  = care;
        @(posedge clk);
        @(negedge clk);
        upd_valid = 1'b0;
        check(upd_busy == 1'b1, "R5", $sformatf("busy=%0b", upd_busy), "busy=1 after request");
        for (int k = 1; k <= 64; k++) begin
            logic [KEY_W-1:0] key;
            if (intr && k == 10) begin
                upd_valid = 1'b1;
                upd_idx   = IW'(intr_idx);
                upd_value = ~val;
                upd_care  = '1;
            end
            if (k % 2 == 0) begin
                key = val ^ (KEY_W'($urandom) & ~care);
                search(key, 1'b1, idx, "R7");
            end else begin
                key = m_vld[k % NR] ? noisy(k % NR) : KEY_W'($urandom);
                search(key, 1'b1, idx, "R8");
            end
            upd_valid = 1'b0;
            check(upd_busy == (k < 64), "R5", $sformatf("busy=%0b at cycle %0d", upd_busy, k),
                  $sformatf("busy=%0b", k < 64));
        end
        m_val[idx]  = val;
        m_care[idx] = care;
        m_vld[idx]  = 1'b1;
        if (intr) begin
            @(negedge clk);
            check(upd_busy == 1'b0, "R6", $sformatf("busy=%0b", upd_busy), "busy=0, request ignored");
            search(~val, 1'b0, 0, "R6");
        end
        search(val ^ (KEY_W'($urandom) & ~care), 1'b0, 0, "R9");
    endtask

    initial begin
        void'($urandom(32'h5eed_7c4a));
        for (int i = 0; i < NR; i++) begin
            m_val[i] = '0; m_care[i] = '0; m_vld[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(!upd_busy && !res_valid && !res_hit, "R10",
              $sformatf("busy=%0b v=%0b hit=%0b", upd_busy, res_valid, res_hit), "all 0");
        @(negedge clk);
        check(!res_valid, "R1", $sformatf("v=%0b", res_valid), "v=0 with no search");
        search(12'h000, 1'b0, 0, "R10");
        search(12'hFFF, 1'b0, 0, "R4");

        // Directed: full wildcard in rule 5, exact rule 2, partial rule 6.
        update(5, 12'h000, 12'h000, 1'b0, 0);
        search(12'h9C3, 1'b0, 0, "R2");
        update(2, 12'hA5C, 12'hFFF, 1'b1, 1);
        search(12'hA5C, 1'b0, 0, "R3");
        search(12'hA5D, 1'b0, 0, "R2");
        update(6, 12'h300, 12'hF00, 1'b1, 3);
        search(12'h3AB, 1'b0, 0, "R3");
        update(2, 12'h111, 12'hFFF, 1'b0, 0);
        search(12'hA5C, 1'b0, 0, "R9");
        update(5, 12'h800, 12'h800, 1'b0, 0);
        search(12'h123, 1'b0, 0, "R4");

        // Random rewrites with searches running alongside.
        for (int n = 0; n < 14; n++) begin
            int r;
            logic [KEY_W-1:0] c;
            r = int'($urandom_range(NR - 1, 0));
            c = KEY_W'($urandom) | KEY_W'($urandom);
            update(r, KEY_W'($urandom), c, n % 3 == 0, (r + 1) % NR);
        end
        for (int n = 0; n < 60; n++) begin
            logic [KEY_W-1:0] key;
            key = (n % 2 == 0) ? noisy(n % NR) : KEY_W'($urandom);
            search(key, 1'b0, 0, (n % 2 == 0) ? "R3" : "R2");
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual run still going expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule